// File: doc/BRIEF.md
# Overcurrent Circuit-Breaker Fault Controller

This block supervises the steady-state load current of a protected power path. Two digitised comparator results come in: one says the load current is above the overcurrent limit, the other says it is above the short-circuit limit. A short overload starts a blanking timer. If the overload ends before the timer runs out, the switch stays on. The event is flagged and recorded with a relative timestamp in a seven-slot circular log. If the overload is still present when the timer runs out, the pass-switch enable drops in that same cycle. The block then latches a set of fault status bits, lowers power-good, and raises a host alert and a fault pin, each of which can be masked.

After a trip the block does one of two things, chosen by configuration. It can stay off until the host issues a clear-faults command. Or it can wait for a programmable cool-down time and then switch back on with a fresh blanking interval. The blanking time, the cool-down time, the masks and the mode are all written through a small parallel register port. Both times are counted in ticks of a clock divider.

Top module: `ocb_ctrl`

## Requirements
- R1: Both comparator inputs pass through a two-flop synchroniser. The blanking timer advances, one count per tick (a tick is every DIV clocks), only while the overcurrent input is high and the short-circuit input is low. While both are high the timer holds, and no trip occurs.
- R2: If the overcurrent input falls before the timer reaches its limit, the switch enable stays high and the timer returns to zero.
- R3: Overloads do not accumulate. Every new overload needs the full blanking interval before a trip, however many short overloads came before it.
- R4: The trip happens when the timer equals the blanking register (address 1, reset value 10 ticks), which the host may rewrite at any time. `sw_en` falls in the same cycle that the timer reaches the limit with the overload still present.
- R5: A trip sets these status bits at address 0: switch-off (bit 0), output-status (bit 1), input-status (bit 2), overcurrent-fault (bit 3) and power-good-bad (bit 4). `pg` is low whenever `sw_en` is low.
- R6: An overload that ends before expiry sets the transient-detect status bit (bit 5). If the slot at the pointer is free, the block also writes an entry. The entry is read at address 8+i and holds valid in bit 31, event id 0x01 in bits 23:16, and the tick timestamp in bits 15:0.
- R7: The log pointer (read at address 5) advances after each written entry, by one up to 6 and then back to 0. When the slot at the pointer is already occupied, nothing is written and the pointer does not move.
- R8: `alert` is high when any of input-status, power-good-bad or output-status is set and not masked. The masks are bits 1, 2 and 3 of the configuration register (address 3).
- R9: `fault` is high when overcurrent-fault is set and configuration bit 4 (the fault-pin mask) is clear.
- R10: Status bits are sticky. They clear only through a write-one-to-clear at address 0, or through a write to address 4 with bit 0 set (clear all faults). Writing address 4 with bit 1 set empties the log and resets the pointer to 0.
- R11: Configuration bit 0 selects auto-retry. In auto-retry mode the switch turns back on after the cool-down register (address 2, reset value 20 ticks) has elapsed, and the blanking timer starts from zero. With bit 0 clear, the switch stays off until a clear-faults command.
- R12: After reset: `sw_en` and `pg` are high, `alert` and `fault` are low, status is 0, configuration is 0, and the log pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_raw | input | 1 | Asynchronous comparator: load above overcurrent limit |
| sc_raw | input | 1 | Asynchronous comparator: load above short-circuit limit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational on address) |
| sw_en | output | 1 | Pass-switch enable |
| pg | output | 1 | Power-good |
| alert | output | 1 | Maskable host alert, active high |
| fault | output | 1 | Maskable fault pin, active high |

## Verification
A persistent overload is driven and the trip time is measured in cycles. This tells a correct blanking count apart from one that is off by a tick or set by the wrong register. A transient pulse followed at once by a long overload shows whether the timer really restarts. A train of sub-limit pulses separates a restarting timer from one that accumulates. An overload held together with the short-circuit input, plus runs of eight transients, exercise the timer hold, the pointer wrap at six and the refusal to overwrite an occupied slot. Trips under different mask and retry settings show which outputs are gated by which bit, and whether the switch comes back by itself.

// File: rtl/ocb_pkg.sv
package ocb_pkg;

    localparam int ADR_STATUS   = 0;
    localparam int ADR_BLANK    = 1;
    localparam int ADR_COOL     = 2;
    localparam int ADR_CFG      = 3;
    localparam int ADR_CMD      = 4;
    localparam int ADR_PTR      = 5;
    localparam int ADR_LOG_BASE = 8;

    localparam logic [7:0] EV_ID_TRANSIENT = 8'h01;

    // bit 0 is the last member
    typedef struct packed {
        logic oc_det;
        logic pg_bad;
        logic oc_fault;
        logic in_stat;
        logic out_stat;
        logic sw_off;
    } ocb_status_t;

    typedef struct packed {
        logic mask_flt;
        logic mask_out;
        logic mask_pg;
        logic mask_in;
        logic auto_retry;
    } ocb_cfg_t;

    localparam int ST_W  = $bits(ocb_status_t);
    localparam int CFG_W = $bits(ocb_cfg_t);

    typedef enum logic [1:0] {
        BRK_ON      = 2'd0,
        BRK_COOL    = 2'd1,
        BRK_LATCHED = 2'd2
    } brk_state_e;

    function automatic ocb_status_t trip_set_bits();
        ocb_status_t s;
        s          = '0;
        s.sw_off   = 1'b1;
        s.out_stat = 1'b1;
        s.in_stat  = 1'b1;
        s.oc_fault = 1'b1;
        s.pg_bad   = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/ocb_sync.sv
module ocb_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [1:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= '0;
            else     sh <= {sh[0], d[b]};
        end
        assign q[b] = sh[1];
    end
endmodule

// File: rtl/ocb_tick.sv
module ocb_tick #(
    parameter int DIV = 8,
    parameter int TSW = 16
) (
    input  logic           clk,
    input  logic           rst,
    output logic           tick,
    output logic [TSW-1:0] stamp
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] div_q;

    assign tick = (div_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            stamp <= '0;
        end else begin
            div_q <= tick ? '0 : div_q + 1'b1;
            if (tick) stamp <= stamp + 1'b1;
        end
    end
endmodule

// File: rtl/ocb_evlog.sv
module ocb_evlog #(
    parameter int DEPTH = 7,
    parameter int TSW   = 16,
    parameter int PW    = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ev,
    input  logic [TSW-1:0] stamp,
    input  logic           clr,
    input  logic [PW-1:0]  rd_idx,
    output logic [PW-1:0]  ptr,
    output logic           rd_valid,
    output logic [TSW-1:0] rd_ts
);
    logic [DEPTH-1:0] vld;
    logic [TSW-1:0]   ts_mem [DEPTH];
    logic             wr_ok;

    assign wr_ok = ev && !vld[ptr];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            vld <= '0;
            ptr <= '0;
        end else if (wr_ok) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (ptr == PW'(i)) begin
                    vld[i]    <= 1'b1;
                    ts_mem[i] <= stamp;
                end
            end
            ptr <= (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        rd_ts    = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == PW'(i)) begin
                rd_valid = vld[i];
                rd_ts    = vld[i] ? ts_mem[i] : '0;
            end
        end
    end
endmodule

// File: rtl/ocb_ctrl.sv
module ocb_ctrl
    import ocb_pkg::*;
#(
    parameter int TW        = 16,
    parameter int DIV       = 8,
    parameter int LOG_DEPTH = 7,
    parameter int TSW       = 16,
    parameter int AW        = 4,
    parameter int DW        = 32,
    parameter int BLANK_RST = 10,
    parameter int COOL_RST  = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          oc_raw,
    input  logic          sc_raw,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          sw_en,
    output logic          pg,
    output logic          alert,
    output logic          fault
);
    localparam int PW = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1;

    logic           oc_s, sc_s, over;
    logic           tick;
    logic [TSW-1:0] stamp;

    ocb_sync #(.W(2)) u_sync (
        .clk(clk), .rst(rst), .d({sc_raw, oc_raw}), .q({sc_s, oc_s})
    );

    ocb_tick #(.DIV(DIV), .TSW(TSW)) u_tick (
        .clk(clk), .rst(rst), .tick(tick), .stamp(stamp)
    );

    // host register decode
    logic wr_status, wr_cmd, cmd_clr_flt, cmd_clr_log;
    assign wr_status   = reg_wr && (reg_addr == AW'(ADR_STATUS));
    assign wr_cmd      = reg_wr && (reg_addr == AW'(ADR_CMD));
    assign cmd_clr_flt = wr_cmd && reg_wdata[0];
    assign cmd_clr_log = wr_cmd && reg_wdata[1];

    logic [TW-1:0] blank_q, cool_lim_q;
    ocb_cfg_t      cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            blank_q    <= TW'(BLANK_RST);
            cool_lim_q <= TW'(COOL_RST);
            cfg_q      <= '0;
        end else if (reg_wr) begin
            if (reg_addr == AW'(ADR_BLANK)) blank_q    <= reg_wdata[TW-1:0];
            if (reg_addr == AW'(ADR_COOL))  cool_lim_q <= reg_wdata[TW-1:0];
            if (reg_addr == AW'(ADR_CFG))   cfg_q      <= ocb_cfg_t'(reg_wdata[CFG_W-1:0]);
        end
    end

    // breaker state machine and blanking timer
    brk_state_e    state_q;
    logic [TW-1:0] tmr_q, cool_q;
    logic          ovl_q;
    logic          trip, ev_trans;

    assign over     = oc_s && !sc_s;
    assign trip     = (state_q == BRK_ON) && over && (tmr_q >= blank_q);
    assign ev_trans = (state_q == BRK_ON) && ovl_q && !oc_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BRK_ON;
            tmr_q   <= '0;
            cool_q  <= '0;
            ovl_q   <= 1'b0;
        end else begin
            unique case (state_q)
                BRK_ON: begin
                    if (trip) begin
                        state_q <= cfg_q.auto_retry ? BRK_COOL : BRK_LATCHED;
                        tmr_q   <= '0;
                        cool_q  <= '0;
                        ovl_q   <= 1'b0;
                    end else if (over) begin
                        ovl_q <= 1'b1;
                        if (tick && (tmr_q < blank_q)) tmr_q <= tmr_q + 1'b1;
                    end else if (!oc_s) begin
                        ovl_q <= 1'b0;
                        tmr_q <= '0;
                    end
                end
                BRK_COOL: begin
                    if (cool_q >= cool_lim_q) begin
                        state_q <= BRK_ON;
                        tmr_q   <= '0;
                    end else if (tick) begin
                        cool_q <= cool_q + 1'b1;
                    end
                end
                BRK_LATCHED: begin
                    if (cmd_clr_flt) begin
                        state_q <= BRK_ON;
                        tmr_q   <= '0;
                    end
                end
                default: state_q <= BRK_LATCHED;
            endcase
        end
    end

    // sticky status: a set in the same cycle beats a clear
    ocb_status_t st_q, st_set, st_clr;

    always_comb begin
        st_set = '0;
        if (trip)     st_set = trip_set_bits();
        if (ev_trans) st_set.oc_det = 1'b1;
        st_clr = '0;
        if (wr_status)   st_clr = ocb_status_t'(reg_wdata[ST_W-1:0]);
        if (cmd_clr_flt) st_clr = '1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= ocb_status_t'((st_q & ~st_clr) | st_set);
    end

    // transient event log
    logic [PW-1:0]  log_ptr, rd_idx;
    logic           rd_valid;
    logic [TSW-1:0] rd_ts;

    assign rd_idx = PW'(reg_addr - AW'(ADR_LOG_BASE));

    ocb_evlog #(.DEPTH(LOG_DEPTH), .TSW(TSW), .PW(PW)) u_log (
        .clk(clk), .rst(rst), .ev(ev_trans), .stamp(stamp),
        .clr(cmd_clr_log), .rd_idx(rd_idx), .ptr(log_ptr),
        .rd_valid(rd_valid), .rd_ts(rd_ts)
    );

    // outputs
    assign sw_en = (state_q == BRK_ON) && !trip;
    assign pg    = sw_en;
    assign alert = (st_q.in_stat  && !cfg_q.mask_in)  ||
                   (st_q.pg_bad   && !cfg_q.mask_pg)  ||
                   (st_q.out_stat && !cfg_q.mask_out);
    assign fault = st_q.oc_fault && !cfg_q.mask_flt;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(ADR_STATUS))      reg_rdata[ST_W-1:0]  = st_q;
        else if (reg_addr == AW'(ADR_BLANK))  reg_rdata[TW-1:0]    = blank_q;
        else if (reg_addr == AW'(ADR_COOL))   reg_rdata[TW-1:0]    = cool_lim_q;
        else if (reg_addr == AW'(ADR_CFG))    reg_rdata[CFG_W-1:0] = cfg_q;
        else if (reg_addr == AW'(ADR_PTR))    reg_rdata[PW-1:0]    = log_ptr;
        else if (reg_addr >= AW'(ADR_LOG_BASE) && rd_valid) begin
            reg_rdata[DW-1]    = 1'b1;
            reg_rdata[23:16]   = EV_ID_TRANSIENT;
            reg_rdata[TSW-1:0] = rd_ts;
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata;
endmodule

// File: rtl/ocb_ctrl_chk.sv
module ocb_ctrl_chk
    import ocb_pkg::*;
#(
    parameter int TW        = 16,
    parameter int PW        = 3,
    parameter int LOG_DEPTH = 7,
    parameter int AW        = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          sw_en,
    input logic          alert,
    input logic          fault,
    input logic          oc_s,
    input ocb_status_t   st,
    input ocb_cfg_t      cfg,
    input logic [TW-1:0] blank,
    input logic [PW-1:0] ptr,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr
);
    logic host_clr;
    assign host_clr = reg_wr && (reg_addr == AW'(ADR_STATUS) || reg_addr == AW'(ADR_CMD));

    // R4, R5: a falling enable is always followed by the trip status
    a_r5_trip_status: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_en) |=> (st.sw_off && st.oc_fault && st.pg_bad));

    // R2: with no overcurrent the switch cannot drop in the next cycle
    a_r2_no_trip_idle: assert property (@(posedge clk) disable iff (rst)
        (sw_en && !oc_s && blank != '0 && !reg_wr) |=> sw_en);

    // R7
    a_r7_ptr_range: assert property (@(posedge clk) disable iff (rst)
        int'(ptr) < LOG_DEPTH);

    // R8
    a_r8_alert_masked: assert property (@(posedge clk) disable iff (rst)
        (cfg.mask_in && cfg.mask_pg && cfg.mask_out) |-> !alert);

    // R9
    a_r9_fault_masked: assert property (@(posedge clk) disable iff (rst)
        cfg.mask_flt |-> !fault);

    // R10
    a_r10_fault_sticky: assert property (@(posedge clk) disable iff (rst)
        (st.oc_fault && !host_clr) |=> st.oc_fault);

    logic unused_cfg;
    assign unused_cfg = cfg.auto_retry;
endmodule

bind ocb_ctrl ocb_ctrl_chk #(
    .TW(TW), .PW(PW), .LOG_DEPTH(LOG_DEPTH), .AW(AW)
) u_chk (
    .clk(clk), .rst(rst), .sw_en(sw_en), .alert(alert), .fault(fault),
    .oc_s(oc_s), .st(st_q), .cfg(cfg_q), .blank(blank_q), .ptr(log_ptr),
    .reg_wr(reg_wr), .reg_addr(reg_addr)
);

// File: tb/ocb_ctrl_tb.sv
module ocb_ctrl_tb;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        oc_raw = 1'b0, sc_raw = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sw_en, pg, alert, fault;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ocb_ctrl #(.DIV(DIV)) u_dut (
        .clk(clk), .rst(rst), .oc_raw(oc_raw), .sc_raw(sc_raw),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sw_en(sw_en), .pg(pg), .alert(alert), .fault(fault)
    );

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a);
        #2 d = reg_rdata;
    endtask

    // hold oc until sw_en drops; n = cycles from assertion to drop
    task automatic run_to_trip(int maxc, output int n);
        @(negedge clk);
        oc_raw = 1'b1;
        n = 0;
        while (sw_en && n < maxc) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse(int len, int gap);
        @(negedge clk);
        oc_raw = 1'b1;
        cyc(len);
        oc_raw = 1'b0;
        cyc(gap);
    endtask

    task automatic clear_all();
        wr(4, 32'h3);
        cyc(2);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk(sw_en == 1 && pg == 1, "R12", "sw_en/pg after reset", {sw_en, pg}, 2'b11);
        chk(alert == 0 && fault == 0, "R12", "alert/fault after reset", {alert, fault}, 0);
        rd(0, d); chk(d == 0, "R12", "status", d, 0);
        rd(1, d); chk(d == 10, "R12", "blank reset", d, 10);
        rd(2, d); chk(d == 20, "R12", "cool reset", d, 20);
        rd(3, d); chk(d == 0, "R12", "cfg reset", d, 0);
        rd(5, d); chk(d == 0, "R12", "ptr reset", d, 0);
    endtask

    task automatic t_transient();
        logic [31:0] d;
        bit stayed = 1;
        @(negedge clk); oc_raw = 1'b1;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (!sw_en) stayed = 0; end
        oc_raw = 1'b0;
        cyc(6);
        chk(stayed && sw_en, "R2", "switch stays on in short overload", sw_en, 1);
        rd(0, d); chk(d == 32'h20, "R6", "transient detect only", d, 32'h20);
        rd(5, d); chk(d == 1, "R7", "ptr after one event", d, 1);
        rd(8, d); chk(d[31] == 1 && d[23:16] == 8'h01, "R6", "entry0 valid/id", d[31:16], 16'h8001);
        chk(alert == 0 && fault == 0, "R8", "no alert for transient", {alert, fault}, 0);
    endtask

    task automatic t_full_interval_after_transient();
        int n;
        logic [31:0] d;
        pulse(30, 6);
        run_to_trip(200, n);
        chk(n >= 38 && n <= 47, "R3", "trip time after transient", n, 42);
        chk(pg == 0, "R5", "pg low on trip", pg, 0);
        oc_raw = 1'b0;
        cyc(1);
        rd(0, d); chk(d[4:0] == 5'h1F, "R5", "trip status bits", d[4:0], 5'h1F);
        chk(alert == 1 && fault == 1, "R8", "alert/fault unmasked", {alert, fault}, 2'b11);
        cyc(150);
        chk(sw_en == 0, "R11", "latched off stays off", sw_en, 0);
        rd(0, d); chk(d[3] == 1, "R10", "fault bit sticky after load gone", d[3], 1);
        wr(4, 32'h1);
        cyc(1);
        chk(sw_en == 1, "R11", "clear-faults re-enables", sw_en, 1);
        rd(0, d); chk(d == 0, "R10", "clear-faults empties status", d, 0);
    endtask

    task automatic t_no_accumulate();
        bit stayed = 1;
        for (int p = 0; p < 4; p++) begin
            @(negedge clk); oc_raw = 1'b1;
            for (int i = 0; i < 30; i++) begin @(negedge clk); if (!sw_en) stayed = 0; end
            oc_raw = 1'b0;
            for (int i = 0; i < 6; i++) begin @(negedge clk); if (!sw_en) stayed = 0; end
        end
        chk(stayed, "R3", "sub-limit pulse train never trips", stayed, 1);
    endtask

    task automatic t_runtime_blank_and_masks();
        int n;
        logic [31:0] d;
        wr(1, 3);
        wr(3, 32'h1E);
        run_to_trip(100, n);
        chk(n >= 10 && n <= 19, "R4", "trip with blank=3", n, 14);
        oc_raw = 1'b0;
        cyc(2);
        chk(alert == 0, "R8", "alert masked", alert, 0);
        chk(fault == 0, "R9", "fault masked", fault, 0);
        wr(3, 32'h1A);
        cyc(1);
        chk(alert == 1, "R8", "pg-bad unmasked drives alert", alert, 1);
        chk(fault == 0, "R9", "fault still masked", fault, 0);
        wr(3, 32'h00);
        cyc(1);
        chk(fault == 1, "R9", "fault unmasked", fault, 1);
        clear_all();
    endtask

    task automatic t_short_hold();
        bit stayed = 1;
        @(negedge clk); oc_raw = 1'b1; sc_raw = 1'b1;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (!sw_en) stayed = 0; end
        oc_raw = 1'b0; sc_raw = 1'b0;
        cyc(6);
        chk(stayed && sw_en, "R1", "no trip while short-circuit input high", stayed, 1);
        clear_all();
    endtask

    task automatic t_retry();
        int n, back;
        logic [31:0] d;
        bit stayed = 1;
        wr(3, 32'h1);
        wr(2, 5);
        run_to_trip(100, n);
        oc_raw = 1'b0;
        back = 0;
        while (!sw_en && back < 100) begin @(negedge clk); back++; end
        chk(back >= 16 && back <= 26, "R11", "auto-retry cool-down cycles", back, 20);
        for (int i = 0; i < 60; i++) begin @(negedge clk); if (!sw_en) stayed = 0; end
        chk(stayed, "R11", "stays on after retry", stayed, 1);
        rd(0, d); chk(d[0] == 1, "R10", "switch-off bit survives retry", d[0], 1);
        wr(0, 32'h1);
        rd(0, d); chk(d == 32'h1E, "R10", "write-one-to-clear bit 0 only", d, 32'h1E);
        run_to_trip(100, n);
        chk(n >= 10 && n <= 19, "R11", "fresh blanking after retry", n, 14);
        oc_raw = 1'b0;
        wr(3, 32'h0);
        cyc(40);
        clear_all();
        wr(1, 10);
    endtask

    task automatic t_log_wrap();
        logic [31:0] d, prev, first;
        bit all_ok = 1, mono = 1;
        clear_all();
        rd(5, d); chk(d == 0, "R10", "log clear resets pointer", d, 0);
        for (int k = 0; k < 7; k++) pulse(10, 8);
        rd(5, d); chk(d == 0, "R7", "pointer wraps after slot 6", d, 0);
        prev = 0;
        for (int k = 0; k < 7; k++) begin
            rd(8 + k, d);
            if (!(d[31] && d[23:16] == 8'h01)) all_ok = 0;
            if (k > 0 && d[15:0] <= prev[15:0]) mono = 0;
            prev = d;
        end
        chk(all_ok, "R6", "seven entries valid with id", all_ok, 1);
        chk(mono, "R6", "timestamps increase", mono, 1);
        rd(8, first);
        wr(0, 32'h3F);
        pulse(10, 8);
        rd(5, d); chk(d == 0, "R7", "pointer holds when slot occupied", d, 0);
        rd(8, d); chk(d == first, "R7", "occupied slot not overwritten", d, first);
        rd(0, d); chk(d == 32'h20, "R6", "detect flag without free slot", d, 32'h20);
    endtask

    initial begin
        cyc(4);
        rst = 1'b0;
        cyc(2);
        t_reset();
        t_transient();
        t_full_interval_after_transient();
        t_no_accumulate();
        t_runtime_blank_and_masks();
        t_short_hold();
        t_retry();
        t_log_wrap();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule